// File: doc/BRIEF.md
# DMA Channel FIFO Transfer Scheduler

This block holds the transfer decisions for one DMA channel that carries a block of data from a source, through a byte-wide channel FIFO, to a destination. It counts the bytes held in the FIFO and the bytes each side still has to move. Every cycle it decides whether the source side should fetch or the destination side should drain. For the transaction it requests it gives the item count, the item width, and whether it is a burst, a plain single, or a flush single. The bus protocol, address generation and descriptor handling sit outside; this block only raises a request and waits for the matching grant.

A block starts with a one-cycle `start` while the channel is idle. The configuration and the byte count are captured at that edge. Each side can be a memory or a peripheral. On a peripheral side the programmed burst size is used. On a memory side the burst size is ignored, and the length is worked out each cycle from FIFO occupancy and the data still owed. A readiness mode picks between immediate readiness and half-full / half-empty thresholds. At the end of a block the destination falls back first to singles of destination width and then to a flush in source-width singles, until the FIFO is empty.

Top module: `fifo_xfer_sched`

## Requirements
- R1: After reset and while idle, `src_req`, `dst_req`, `busy` and `blk_done` are all low.
- R2: `start` is accepted only while `busy` is low. It captures the configuration and `cfg_blk_bytes`, which must be nonzero and a multiple of the source width. A `start` while busy is ignored and changes neither the running block nor its byte total.
- R3: With `cfg_half_mode`=0, a memory destination is ready as soon as one destination item is held. The source is ready once the FIFO has room for its whole transaction.
- R4: With `cfg_half_mode`=1, before the source has finished the block, a non-flush drain needs at least FIFO_BYTES/2 bytes held. A fetch needs at least FIFO_BYTES/2 bytes free.
- R5: With `cfg_half_mode`=1, the half-full drain condition is waived once the source has delivered the whole block, so the FIFO always empties.
- R6: Encodings: `cfg_dir` bit 1 = source is a peripheral, bit 0 = destination is a peripheral. Width code w means 2^w bytes per item. Burst code m means 2^m items. A peripheral source issues bursts of 2^m items (burst flag 1) while at least that many bytes remain. Otherwise it issues singles of the source width (burst flag 0).
- R7: A peripheral destination issues bursts of 2^m destination items. Once the source has finished and fewer bytes than one burst are held, it issues singles of the destination width.
- R8: Once the source has finished and fewer bytes than one destination item are held but data is still owed, the destination issues flush singles. These have `dst_flush`=1, `dst_burst`=0, a length of 1 and the source width.
- R9: A memory side ignores its burst code and always flags burst. A memory source fetches min(free bytes, bytes left to fetch) / source width items. A memory destination drains min(held bytes, bytes left to drain) / destination width items.
- R10: At most one request is raised at a time. When both sides could start, the drain is requested.
- R11: A request that is not granted stays raised, with its length, width, burst and flush outputs unchanged.
- R12: `blk_done` pulses for one cycle, the cycle after the grant that drains the last byte. The FIFO is then empty and `busy` is low. Bytes fetched and bytes drained both equal the block size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block when idle |
| cfg_dir | input | 2 | Bit 1 source is peripheral, bit 0 destination is peripheral |
| cfg_half_mode | input | 1 | 1 selects half-full / half-empty readiness |
| cfg_src_wlog | input | 2 | Source item width code (2^w bytes) |
| cfg_dst_wlog | input | 2 | Destination item width code |
| cfg_src_msz | input | 2 | Source burst code (2^m items) |
| cfg_dst_msz | input | 2 | Destination burst code |
| cfg_blk_bytes | input | BLK_W | Block size in bytes |
| src_gnt | input | 1 | Source transaction granted |
| dst_gnt | input | 1 | Destination transaction granted |
| src_req | output | 1 | Source fetch requested |
| src_burst | output | 1 | Source transaction is a burst |
| src_len | output | LEN_W | Source item count |
| src_wlog | output | 2 | Source item width code |
| dst_req | output | 1 | Destination drain requested |
| dst_burst | output | 1 | Destination transaction is a burst |
| dst_flush | output | 1 | Destination transaction is a flush single |
| dst_len | output | LEN_W | Destination item count |
| dst_wlog | output | 2 | Destination item width code for this transaction |
| busy | output | 1 | Block in progress |
| blk_done | output | 1 | One-cycle block completion pulse |

## Verification
The bench uses the defaults FIFO_BYTES=16 and BLK_W=12. That puts the half threshold at 8 bytes, so a 1-item, 4-byte peripheral source shows a clear difference between the two readiness modes. With item widths of 1, 2 and 4 bytes, mixed widths give end-of-block residues that are smaller than one destination item. These lead into both the destination-single phase and the flush phase within blocks of a few tens of bytes. Burst codes up to 3 on memory sides would overflow the FIFO if they were obeyed, so ignoring them is observable.

// File: rtl/fifo_xfer_sched_pkg.sv
package fifo_xfer_sched_pkg;
  typedef enum logic [1:0] {
    XFER_M2M = 2'b00,
    XFER_M2P = 2'b01,
    XFER_P2M = 2'b10,
    XFER_P2P = 2'b11
  } xfer_dir_e;

  typedef struct packed {
    xfer_dir_e  dir;
    logic       half_mode;
    logic [1:0] src_wlog;
    logic [1:0] dst_wlog;
    logic [1:0] src_msz;
    logic [1:0] dst_msz;
  } chan_cfg_t;
endpackage

// File: rtl/chan_fetch_ctl.sv
module chan_fetch_ctl #(
  parameter int FIFO_BYTES = 16,
  parameter int BLK_W      = 12,
  parameter int LEN_W      = 5
) (
  input  logic             mem_side,
  input  logic             half_mode,
  input  logic [1:0]       wlog,
  input  logic [1:0]       msz,
  input  logic [BLK_W-1:0] occ,
  input  logic [BLK_W-1:0] rem,
  output logic             ready,
  output logic             burst,
  output logic [LEN_W-1:0] len,
  output logic [BLK_W-1:0] bytes
);
  localparam int HALF = FIFO_BYTES / 2;

  logic [BLK_W-1:0] space, fit_items, rem_items, pick, pburst;

  always_comb begin
    space     = BLK_W'(FIFO_BYTES) - occ;
    fit_items = space >> wlog;
    rem_items = rem >> wlog;
    pburst    = BLK_W'(1) << ({1'b0, msz} + {1'b0, wlog});
    if (mem_side) begin
      // memory source: length follows free space and what is left
      burst = 1'b1;
      pick  = (fit_items < rem_items) ? fit_items : rem_items;
    end else if (rem >= pburst) begin
      burst = 1'b1;
      pick  = BLK_W'(1) << msz;
    end else begin
      burst = 1'b0;
      pick  = BLK_W'(1);
    end
    bytes = pick << wlog;
    len   = LEN_W'(pick);
    ready = (rem != '0) && (pick != '0) && (space >= bytes) &&
            (!half_mode || (space >= BLK_W'(HALF)));
  end
endmodule

// File: rtl/chan_drain_ctl.sv
module chan_drain_ctl #(
  parameter int FIFO_BYTES = 16,
  parameter int BLK_W      = 12,
  parameter int LEN_W      = 5
) (
  input  logic             mem_side,
  input  logic             half_mode,
  input  logic             src_done,
  input  logic [1:0]       dwlog,
  input  logic [1:0]       swlog,
  input  logic [1:0]       msz,
  input  logic [BLK_W-1:0] occ,
  input  logic [BLK_W-1:0] rem,
  output logic             ready,
  output logic             burst,
  output logic             flush,
  output logic [1:0]       wlog,
  output logic [LEN_W-1:0] len,
  output logic [BLK_W-1:0] bytes
);
  localparam int HALF = FIFO_BYTES / 2;

  logic [BLK_W-1:0] dsz, pburst, held_items, rem_items, pick;
  logic             gate;

  always_comb begin
    dsz        = BLK_W'(1) << dwlog;
    pburst     = BLK_W'(1) << ({1'b0, msz} + {1'b0, dwlog});
    held_items = occ >> dwlog;
    rem_items  = rem >> dwlog;
    // half-full rule, waived once the source side is complete
    gate       = !half_mode || src_done || (occ >= BLK_W'(HALF));
    flush      = 1'b0;
    burst      = 1'b0;
    wlog       = dwlog;
    if (rem == '0) begin
      pick = '0;
    end else if (src_done && (occ < dsz)) begin
      flush = 1'b1;
      wlog  = swlog;
      pick  = BLK_W'(1);
    end else if (mem_side) begin
      burst = 1'b1;
      pick  = (held_items < rem_items) ? held_items : rem_items;
    end else if (occ >= pburst) begin
      burst = 1'b1;
      pick  = BLK_W'(1) << msz;
    end else if (src_done) begin
      pick = BLK_W'(1);
    end else begin
      pick = '0;
    end
    bytes = pick << wlog;
    len   = LEN_W'(pick);
    ready = (pick != '0) && (occ >= bytes) && (flush || gate);
  end
endmodule

// File: rtl/chan_level_trk.sv
module chan_level_trk #(
  parameter int FIFO_BYTES = 16,
  parameter int BLK_W      = 12,
  parameter int OCC_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] blk_bytes,
  input  logic             src_fire,
  input  logic [BLK_W-1:0] src_bytes,
  input  logic             dst_fire,
  input  logic [BLK_W-1:0] dst_bytes,
  output logic [OCC_W-1:0] occ,
  output logic [BLK_W-1:0] rem_src,
  output logic [BLK_W-1:0] rem_dst,
  output logic             busy,
  output logic             done
);
  logic [OCC_W-1:0] occ_q, occ_n;
  logic [BLK_W-1:0] rem_src_q, rem_src_n, rem_dst_q, rem_dst_n;
  logic             busy_q, busy_n, done_q, done_n, last_drain;

  always_comb begin
    occ_n      = occ_q;
    rem_src_n  = rem_src_q;
    rem_dst_n  = rem_dst_q;
    busy_n     = busy_q;
    last_drain = dst_fire && (rem_dst_q == dst_bytes);
    done_n     = last_drain;
    if (load) begin
      occ_n     = '0;
      rem_src_n = blk_bytes;
      rem_dst_n = blk_bytes;
      busy_n    = 1'b1;
    end else begin
      if (src_fire) begin
        occ_n     = occ_q + src_bytes[OCC_W-1:0];
        rem_src_n = rem_src_q - src_bytes;
      end
      if (dst_fire) begin
        occ_n     = occ_q - dst_bytes[OCC_W-1:0];
        rem_dst_n = rem_dst_q - dst_bytes;
      end
      if (last_drain) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q     <= '0;
      rem_src_q <= '0;
      rem_dst_q <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      occ_q     <= occ_n;
      rem_src_q <= rem_src_n;
      rem_dst_q <= rem_dst_n;
      busy_q    <= busy_n;
      done_q    <= done_n;
    end
  end

  assign occ     = occ_q;
  assign rem_src = rem_src_q;
  assign rem_dst = rem_dst_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/fifo_xfer_sched.sv
module fifo_xfer_sched #(
  parameter int FIFO_BYTES = 16,
  parameter int BLK_W      = 12,
  parameter int LEN_W      = $clog2(FIFO_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_dir,
  input  logic             cfg_half_mode,
  input  logic [1:0]       cfg_src_wlog,
  input  logic [1:0]       cfg_dst_wlog,
  input  logic [1:0]       cfg_src_msz,
  input  logic [1:0]       cfg_dst_msz,
  input  logic [BLK_W-1:0] cfg_blk_bytes,
  input  logic             src_gnt,
  input  logic             dst_gnt,
  output logic             src_req,
  output logic             src_burst,
  output logic [LEN_W-1:0] src_len,
  output logic [1:0]       src_wlog,
  output logic             dst_req,
  output logic             dst_burst,
  output logic             dst_flush,
  output logic [LEN_W-1:0] dst_len,
  output logic [1:0]       dst_wlog,
  output logic             busy,
  output logic             blk_done
);
  import fifo_xfer_sched_pkg::*;

  localparam int OCC_W = $clog2(FIFO_BYTES + 1);

  chan_cfg_t        cfg_q, cfg_n;
  logic             load;
  logic [OCC_W-1:0] lvl_occ;
  logic [BLK_W-1:0] lvl_rem_src, lvl_rem_dst, occ_ext;
  logic [BLK_W-1:0] fetch_bytes, drain_bytes;
  logic             fetch_rdy, drain_rdy;

  assign load    = start && !busy;
  assign occ_ext = BLK_W'(lvl_occ);

  always_comb begin
    cfg_n = cfg_q;
    if (load) begin
      cfg_n.dir       = xfer_dir_e'(cfg_dir);
      cfg_n.half_mode = cfg_half_mode;
      cfg_n.src_wlog  = cfg_src_wlog;
      cfg_n.dst_wlog  = cfg_dst_wlog;
      cfg_n.src_msz   = cfg_src_msz;
      cfg_n.dst_msz   = cfg_dst_msz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  chan_fetch_ctl #(.FIFO_BYTES(FIFO_BYTES), .BLK_W(BLK_W), .LEN_W(LEN_W)) u_fetch (
    .mem_side  (!cfg_q.dir[1]),
    .half_mode (cfg_q.half_mode),
    .wlog      (cfg_q.src_wlog),
    .msz       (cfg_q.src_msz),
    .occ       (occ_ext),
    .rem       (lvl_rem_src),
    .ready     (fetch_rdy),
    .burst     (src_burst),
    .len       (src_len),
    .bytes     (fetch_bytes)
  );

  chan_drain_ctl #(.FIFO_BYTES(FIFO_BYTES), .BLK_W(BLK_W), .LEN_W(LEN_W)) u_drain (
    .mem_side  (!cfg_q.dir[0]),
    .half_mode (cfg_q.half_mode),
    .src_done  (lvl_rem_src == '0),
    .dwlog     (cfg_q.dst_wlog),
    .swlog     (cfg_q.src_wlog),
    .msz       (cfg_q.dst_msz),
    .occ       (occ_ext),
    .rem       (lvl_rem_dst),
    .ready     (drain_rdy),
    .burst     (dst_burst),
    .flush     (dst_flush),
    .wlog      (dst_wlog),
    .len       (dst_len),
    .bytes     (drain_bytes)
  );

  // drain wins whenever both sides could go
  assign dst_req  = busy && drain_rdy;
  assign src_req  = busy && fetch_rdy && !drain_rdy;
  assign src_wlog = cfg_q.src_wlog;

  chan_level_trk #(.FIFO_BYTES(FIFO_BYTES), .BLK_W(BLK_W), .OCC_W(OCC_W)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .blk_bytes (cfg_blk_bytes),
    .src_fire  (src_req && src_gnt),
    .src_bytes (fetch_bytes),
    .dst_fire  (dst_req && dst_gnt),
    .dst_bytes (drain_bytes),
    .occ       (lvl_occ),
    .rem_src   (lvl_rem_src),
    .rem_dst   (lvl_rem_dst),
    .busy      (busy),
    .done      (blk_done)
  );
endmodule

// File: rtl/fifo_xfer_sched_chk.sv
module fifo_xfer_sched_chk #(
  parameter int FIFO_BYTES = 16,
  parameter int BLK_W      = 12,
  parameter int LEN_W      = 5,
  parameter int OCC_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_req,
  input logic             src_gnt,
  input logic             src_burst,
  input logic [LEN_W-1:0] src_len,
  input logic [1:0]       src_wlog,
  input logic             dst_req,
  input logic             dst_gnt,
  input logic             dst_burst,
  input logic             dst_flush,
  input logic [LEN_W-1:0] dst_len,
  input logic [1:0]       dst_wlog,
  input logic             busy,
  input logic             blk_done,
  input logic             half_mode,
  input logic [OCC_W-1:0] occ,
  input logic [BLK_W-1:0] rem_src
);
  localparam int HALF = FIFO_BYTES / 2;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!src_req && !dst_req));

  p_half_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode && dst_req && !dst_flush && rem_src != '0) |-> (occ >= OCC_W'(HALF)));

  p_half_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode && src_req) |-> (occ <= OCC_W'(FIFO_BYTES - HALF)));

  p_flush_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req && dst_flush) |-> (!dst_burst && dst_len == LEN_W'(1) && dst_wlog == src_wlog));

  p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_req && dst_req));

  p_src_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_gnt) |=> (src_req && $stable(src_len) && $stable(src_burst)));

  p_dst_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req && !dst_gnt) |=> (dst_req && $stable(dst_len) && $stable(dst_burst) &&
                               $stable(dst_flush) && $stable(dst_wlog)));

  p_occ_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(FIFO_BYTES));

  p_done_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (occ == '0 && !busy));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);
endmodule

bind fifo_xfer_sched fifo_xfer_sched_chk #(
  .FIFO_BYTES (FIFO_BYTES),
  .BLK_W      (BLK_W),
  .LEN_W      (LEN_W),
  .OCC_W      (OCC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_req   (src_req),
  .src_gnt   (src_gnt),
  .src_burst (src_burst),
  .src_len   (src_len),
  .src_wlog  (src_wlog),
  .dst_req   (dst_req),
  .dst_gnt   (dst_gnt),
  .dst_burst (dst_burst),
  .dst_flush (dst_flush),
  .dst_len   (dst_len),
  .dst_wlog  (dst_wlog),
  .busy      (busy),
  .blk_done  (blk_done),
  .half_mode (cfg_q.half_mode),
  .occ       (lvl_occ),
  .rem_src   (lvl_rem_src)
);

// File: tb/test_fifo_xfer_sched.sv
module test_fifo_xfer_sched;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W      = 12;
  localparam int LEN_W      = 5;
  localparam int NVEC       = 10;

  typedef struct packed {
    logic [1:0]  dir;
    logic        half;
    logic [1:0]  sw;
    logic [1:0]  dw;
    logic [1:0]  sms;
    logic [1:0]  dms;
    logic [11:0] blk;
    logic [7:0]  sb;
    logic [7:0]  ss;
    logic [7:0]  db;
    logic [7:0]  ds;
    logic [7:0]  fl;
  } vec_t;

  // dir half sw dw sms dms blk | src bursts, src singles, dst bursts, dst singles, flushes
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 2'd2, 2'd2, 2'd3, 2'd3, 12'd32, 8'd2, 8'd0, 8'd2, 8'd0, 8'd0},
    '{2'd0, 1'b0, 2'd0, 2'd2, 2'd0, 2'd0, 12'd20, 8'd2, 8'd0, 8'd2, 8'd0, 8'd0},
    '{2'd2, 1'b0, 2'd2, 2'd2, 2'd0, 2'd0, 12'd32, 8'd8, 8'd0, 8'd8, 8'd0, 8'd0},
    '{2'd2, 1'b1, 2'd2, 2'd2, 2'd0, 2'd0, 12'd32, 8'd8, 8'd0, 8'd4, 8'd0, 8'd0},
    '{2'd1, 1'b0, 2'd2, 2'd2, 2'd0, 2'd1, 12'd20, 8'd2, 8'd0, 8'd2, 8'd1, 8'd0},
    '{2'd0, 1'b0, 2'd0, 2'd2, 2'd0, 2'd0, 12'd6,  8'd1, 8'd0, 8'd1, 8'd0, 8'd2},
    '{2'd1, 1'b0, 2'd1, 2'd2, 2'd0, 2'd1, 12'd14, 8'd1, 8'd0, 8'd1, 8'd1, 8'd1},
    '{2'd3, 1'b0, 2'd1, 2'd1, 2'd2, 2'd2, 12'd12, 8'd1, 8'd2, 8'd1, 8'd2, 8'd0},
    '{2'd2, 1'b0, 2'd2, 2'd2, 2'd1, 2'd0, 12'd32, 8'd4, 8'd0, 8'd4, 8'd0, 8'd0},
    '{2'd0, 1'b1, 2'd0, 2'd2, 2'd0, 2'd0, 12'd6,  8'd1, 8'd0, 8'd1, 8'd0, 8'd2}
  };

  logic             clk, rst_n, start;
  logic [1:0]       cfg_dir, cfg_src_wlog, cfg_dst_wlog, cfg_src_msz, cfg_dst_msz;
  logic             cfg_half_mode;
  logic [BLK_W-1:0] cfg_blk_bytes;
  logic             src_gnt, dst_gnt;
  logic             src_req, src_burst, dst_req, dst_burst, dst_flush, busy, blk_done;
  logic [LEN_W-1:0] src_len, dst_len;
  logic [1:0]       src_wlog, dst_wlog;

  int n_checks = 0;
  int n_errors = 0;

  fifo_xfer_sched #(.FIFO_BYTES(16), .BLK_W(BLK_W), .LEN_W(LEN_W)) i_fifo_xfer_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_dir(cfg_dir),
    .cfg_half_mode(cfg_half_mode), .cfg_src_wlog(cfg_src_wlog), .cfg_dst_wlog(cfg_dst_wlog),
    .cfg_src_msz(cfg_src_msz), .cfg_dst_msz(cfg_dst_msz), .cfg_blk_bytes(cfg_blk_bytes),
    .src_gnt(src_gnt), .dst_gnt(dst_gnt), .src_req(src_req), .src_burst(src_burst),
    .src_len(src_len), .src_wlog(src_wlog), .dst_req(dst_req), .dst_burst(dst_burst),
    .dst_flush(dst_flush), .dst_len(dst_len), .dst_wlog(dst_wlog), .busy(busy),
    .blk_done(blk_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog R12 actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0: return "R9";
      1: return "R3 R9";
      2: return "R3 R6";
      3: return "R4";
      4: return "R7";
      5: return "R8";
      6: return "R7 R8";
      7: return "R6 R7";
      8: return "R6 R9";
      default: return "R5";
    endcase
  endfunction

  task automatic set_cfg(input vec_t v);
    cfg_dir       = v.dir;
    cfg_half_mode = v.half;
    cfg_src_wlog  = v.sw;
    cfg_dst_wlog  = v.dw;
    cfg_src_msz   = v.sms;
    cfg_dst_msz   = v.dms;
    cfg_blk_bytes = v.blk;
  endtask

  // runs one block with grants held high; counts transactions at negedges
  task automatic run_vec(input vec_t v, input string tag);
    int sb = 0, ss = 0, db = 0, ds = 0, fl = 0, sbytes = 0, dbytes = 0, cyc = 0;
    bit last = 1'b0, fin = 1'b0;
    @(negedge clk);
    set_cfg(v);
    start = 1'b1; src_gnt = 1'b1; dst_gnt = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 400) begin
      if (last) begin
        chk({tag, " R12"}, "done pulse after last drain", int'(blk_done), 1);
        chk({tag, " R12"}, "busy low at done", int'(busy), 0);
        fin = 1'b1;
      end else begin
        if (blk_done) chk({tag, " R12"}, "early done", 1, 0);
        if (src_req) begin
          if (src_burst) sb++; else ss++;
          sbytes += int'(src_len) << src_wlog;
        end
        if (dst_req) begin
          if (dst_flush) fl++; else if (dst_burst) db++; else ds++;
          dbytes += int'(dst_len) << dst_wlog;
          if (dbytes >= int'(v.blk)) last = 1'b1;
        end
        @(negedge clk);
        cyc++;
      end
    end
    chk({tag, " R12"}, "block completed", int'(fin), 1);
    chk({tag, " R6 R9"}, "source bursts", sb, int'(v.sb));
    chk({tag, " R6"}, "source singles", ss, int'(v.ss));
    chk({tag, " R7 R9"}, "dest bursts", db, int'(v.db));
    chk({tag, " R7"}, "dest singles", ds, int'(v.ds));
    chk({tag, " R8"}, "flush singles", fl, int'(v.fl));
    chk({tag, " R12"}, "source bytes", sbytes, int'(v.blk));
    chk({tag, " R12"}, "dest bytes", dbytes, int'(v.blk));
  endtask

  initial begin
    vec_t dv;
    int dbytes;
    rst_n = 1'b0; start = 1'b0; src_gnt = 1'b0; dst_gnt = 1'b0;
    set_cfg(VECS[0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "src_req after reset", int'(src_req), 0);
    chk("R1", "dst_req after reset", int'(dst_req), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "blk_done after reset", int'(blk_done), 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], row_tag(i));

    // R10 R11: stalled grants, hold and drain priority
    dv = VECS[8];
    @(negedge clk);
    src_gnt = 1'b0; dst_gnt = 1'b0;
    set_cfg(dv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6", "peripheral source burst length", int'(src_len), 2);
    chk("R6", "peripheral source burst flag", int'(src_burst), 1);
    repeat (3) @(negedge clk);
    chk("R11", "src_req held without grant", int'(src_req), 1);
    chk("R11", "src_len held without grant", int'(src_len), 2);
    src_gnt = 1'b1;
    @(negedge clk);
    src_gnt = 1'b0;
    chk("R10", "drain requested first", int'(dst_req), 1);
    chk("R10", "fetch withheld", int'(src_req), 0);
    chk("R9", "memory drain length", int'(dst_len), 2);
    src_gnt = 1'b1; dst_gnt = 1'b1;
    for (int k = 0; k < 100 && !blk_done; k++) @(negedge clk);
    chk("R12", "stalled block finished", int'(blk_done), 1);

    // R2: start while busy is ignored
    @(negedge clk);
    set_cfg(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    cfg_blk_bytes = 12'd8;
    cfg_src_wlog  = 2'd0;
    dbytes = 0;
    if (dst_req) dbytes += int'(dst_len) << dst_wlog;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 100 && !blk_done; k++) begin
      if (dst_req) dbytes += int'(dst_len) << dst_wlog;
      @(negedge clk);
    end
    chk("R2", "bytes drained with start while busy", dbytes, 32);
    @(negedge clk);
    chk("R2", "idle after ignored start", int'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule